// File: doc/BRIEF.md
# Clock Synthesiser Control Register Front End

This block is the register side of a clock synthesiser. Three 16-bit control words carry the power-down control, bypass, integer feedback and reference dividers, a power-of-two post divider and the fractional-mode settings. Every write is self-masked: the upper half of the write data says which of the lower sixteen bits may change. The decoded fields drive the analog loop directly.

Next to the storage, a small sequential engine works out the output frequency the integer-mode settings would give from a fixed reference. It uses a restoring divider followed by a shift-add multiplier and a final right shift. It restarts whenever a rate-affecting field changes, and it keeps a busy flag raised while it runs. The reported rate word shows the reference rate when bypass is set. It shows a reserved code when fractional mode is selected, and otherwise the last computed rate.

Top module: `pll_cfg_if`

## Requirements
- R1: A write to a word updates only the bits whose enable in write data bits 31:16 is 1, taking them from bits 15:0. Bits with enable 0 keep their value.
- R2: Offsets 0x0, 0x4 and 0x8 read their word in bits 15:0 with bits 31:16 zero. Any other offset reads zero, and writes to it change no word.
- R3: Field layout. Word 0 holds bit 0 power-down control, bit 1 fractional select, bit 2 modulus select, bit 4 phase-rotation select, bits 12:6 fractional value and bit 15 bypass. Word 1 holds post divider R in bits 8:7. Word 2 holds N-1 in bits 7:0 and M-1 in bits 14:8. The ports show M and N decoded as the stored value plus one.
- R4: `pll_enable` is 1 exactly when word 0 bit 0 is 1.
- R5: In integer mode without bypass, the rate word is ((27000000 / M) * N) >> R, with truncating division and saturation at 0xFFFFFFFE.
- R6: With bypass set, the rate word equals the reference rate of 27000000.
- R7: With fractional mode selected and bypass clear, the rate word is 0xFFFFFFFF.
- R8: A write that changes any of word 0 bits 1, 2, 4 or 12:6, word 1 bits 8:7 or word 2 bits 14:0 raises `rate_busy` after that clock edge. Busy stays high for exactly 42 cycles, after which the new rate is shown.
- R9: A write that changes none of those bits (same value, zero mask, or only bit 0 or bit 15) leaves `rate_busy` low.
- R10: A rate-affecting write while busy restarts the engine. The final rate reflects the latest settings, 42 cycles after that write.
- R11: After reset all words are zero, the rate word is 27000000, busy is low and the PLL counts as disabled.
- R12: `frac_modulus` is 91 when the modulus select is 0 and 55 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte offset |
| reg_wdata | input | 32 | Write enables in 31:16, data in 15:0 |
| reg_rdata | output | 32 | Read data for reg_addr |
| pll_enable | output | 1 | Power-down control bit |
| pll_bypass | output | 1 | Bypass select |
| frac_mode | output | 1 | Fractional mode select |
| frac_modulus | output | 7 | Sigma-delta modulus (91 or 55) |
| phase_rot | output | 1 | Phase-rotation select |
| frac_value | output | 7 | Fractional value |
| post_div | output | 2 | Post divider shift R |
| fb_div_m | output | 8 | Decoded M (1 to 128) |
| fb_div_n | output | 9 | Decoded N (1 to 256) |
| rate_busy | output | 1 | Rate computation running |
| rate_word | output | 32 | Reported output rate or fractional code |

## Verification
The assertions assume writes are single-cycle strobes with a stable address and data on the sampling edge. They also assume the rate fields only change through the write path, so a busy run can end only by completion or restart. The stimulus changes inputs only on falling edges and always writes whole, legal encodings. It waits for busy to fall before checking a rate, except in the restart test, which writes again on purpose in the middle of a computation.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int WORD_W  = 16;
  localparam int M_W     = 7;
  localparam int N_W     = 8;
  localparam int R_W     = 2;
  localparam int NFRA_W  = 7;
  localparam int FLD_W   = NFRA_W + 3 + R_W + M_W + N_W;

  typedef enum logic [1:0] {ENG_IDLE, ENG_DIV, ENG_MUL, ENG_FIN} eng_state_e;

  // Self-masked merge: upper half enables, lower half data.
  function automatic logic [WORD_W-1:0] masked_merge(input logic [WORD_W-1:0] cur,
                                                     input logic [31:0] wd);
    return (cur & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endfunction

  // The bits whose change forces a new rate computation.
  function automatic logic [FLD_W-1:0] rate_fields(input logic [WORD_W-1:0] w0,
                                                   input logic [WORD_W-1:0] w1,
                                                   input logic [WORD_W-1:0] w2);
    return {w0[12:6], w0[4], w0[2], w0[1], w1[8:7], w2[14:0]};
  endfunction

  function automatic logic [6:0] modulus_of(input logic sel);
    return sel ? 7'd55 : 7'd91;
  endfunction
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [31:0]       wdata,
  output logic [WORD_W-1:0] w0_q,
  output logic [WORD_W-1:0] w1_q,
  output logic [WORD_W-1:0] w2_q,
  output logic [WORD_W-1:0] w0_nx,
  output logic [WORD_W-1:0] w1_nx,
  output logic [WORD_W-1:0] w2_nx,
  output logic              fields_chg,
  output logic [31:0]       rdata
);
  localparam int NWORDS = 3;

  logic [WORD_W-1:0] word_q  [NWORDS];
  logic [WORD_W-1:0] word_nx [NWORDS];
  logic              addr_ok;

  assign addr_ok = (addr[1:0] == 2'b00) && (addr[3:2] != 2'b11);

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
    always_comb begin
      word_nx[gi] = word_q[gi];
      if (wr && addr_ok && (addr[3:2] == 2'(gi)))
        word_nx[gi] = masked_merge(word_q[gi], wdata);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[gi] <= '0;
      else        word_q[gi] <= word_nx[gi];
    end
  end

  assign w0_q  = word_q[0];
  assign w1_q  = word_q[1];
  assign w2_q  = word_q[2];
  assign w0_nx = word_nx[0];
  assign w1_nx = word_nx[1];
  assign w2_nx = word_nx[2];

  assign fields_chg = rate_fields(word_nx[0], word_nx[1], word_nx[2])
                   != rate_fields(word_q[0], word_q[1], word_q[2]);

  always_comb begin
    unique case (addr)
      4'h0:    rdata = {16'h0000, word_q[0]};
      4'h4:    rdata = {16'h0000, word_q[1]};
      4'h8:    rdata = {16'h0000, word_q[2]};
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/pll_rate_engine.sv
module pll_rate_engine
  import pll_cfg_pkg::*;
#(
  parameter int REF_HZ = 27_000_000,
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [M_W:0]      m_dec,
  input  logic [N_W:0]      n_dec,
  input  logic [R_W-1:0]    r_sh,
  output logic              busy,
  output logic              done,
  output logic [RATE_W-1:0] result
);
  localparam int REM_W  = M_W + 2;
  localparam int PROD_W = RATE_W + N_W + 1;
  localparam int CNT_W  = $clog2(RATE_W + 1);
  localparam logic [RATE_W-1:0] SAT    = {{(RATE_W-1){1'b1}}, 1'b0};
  localparam logic [RATE_W-1:0] REF_V  = RATE_W'(REF_HZ);

  eng_state_e        st_q, st_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [RATE_W-1:0] quot_q, quot_nx;
  logic [REM_W-1:0]  rem_q, rem_nx, rem_sh;
  logic [M_W:0]      dvs_q, dvs_nx;
  logic [N_W:0]      mul_q, mul_nx;
  logic [R_W-1:0]    sh_q, sh_nx;
  logic [PROD_W-1:0] acc_q, acc_nx, add_q, add_nx, shifted;
  logic [RATE_W-1:0] res_q, res_nx;

  always_comb begin
    st_nx   = st_q;
    cnt_nx  = cnt_q;
    quot_nx = quot_q;
    rem_nx  = rem_q;
    dvs_nx  = dvs_q;
    mul_nx  = mul_q;
    sh_nx   = sh_q;
    acc_nx  = acc_q;
    add_nx  = add_q;
    res_nx  = res_q;
    rem_sh  = {rem_q[REM_W-2:0], quot_q[RATE_W-1]};
    shifted = acc_q >> sh_q;
    if (start) begin
      st_nx   = ENG_DIV;
      cnt_nx  = '0;
      quot_nx = REF_V;
      rem_nx  = '0;
      dvs_nx  = m_dec;
      mul_nx  = n_dec;
      sh_nx   = r_sh;
      acc_nx  = '0;
    end else begin
      unique case (st_q)
        ENG_DIV: begin
          quot_nx = {quot_q[RATE_W-2:0], 1'b0};
          rem_nx  = rem_sh;
          if (rem_sh >= REM_W'(dvs_q)) begin
            rem_nx     = rem_sh - REM_W'(dvs_q);
            quot_nx[0] = 1'b1;
          end
          cnt_nx = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(RATE_W - 1)) begin
            st_nx  = ENG_MUL;
            cnt_nx = '0;
            add_nx = PROD_W'(quot_nx);
          end
        end
        ENG_MUL: begin
          if (mul_q[0]) acc_nx = acc_q + add_q;
          add_nx = add_q << 1;
          mul_nx = mul_q >> 1;
          cnt_nx = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(N_W)) st_nx = ENG_FIN;
        end
        ENG_FIN: begin
          res_nx = (shifted > PROD_W'(SAT)) ? SAT : shifted[RATE_W-1:0];
          st_nx  = ENG_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      quot_q <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      mul_q  <= '0;
      sh_q   <= '0;
      acc_q  <= '0;
      add_q  <= '0;
      res_q  <= REF_V;
    end else begin
      st_q   <= st_nx;
      cnt_q  <= cnt_nx;
      quot_q <= quot_nx;
      rem_q  <= rem_nx;
      dvs_q  <= dvs_nx;
      mul_q  <= mul_nx;
      sh_q   <= sh_nx;
      acc_q  <= acc_nx;
      add_q  <= add_nx;
      res_q  <= res_nx;
    end
  end

  assign busy   = (st_q != ENG_IDLE);
  assign done   = (st_q == ENG_FIN);
  assign result = res_q;
endmodule

// File: rtl/pll_cfg_if.sv
module pll_cfg_if
  import pll_cfg_pkg::*;
#(
  parameter int REF_HZ = 27_000_000,
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              pll_enable,
  output logic              pll_bypass,
  output logic              frac_mode,
  output logic [6:0]        frac_modulus,
  output logic              phase_rot,
  output logic [6:0]        frac_value,
  output logic [1:0]        post_div,
  output logic [7:0]        fb_div_m,
  output logic [8:0]        fb_div_n,
  output logic              rate_busy,
  output logic [31:0]       rate_word
);
  localparam logic [RATE_W-1:0] FRAC_CODE = '1;

  logic [WORD_W-1:0] w0_q, w1_q, w2_q, w0_nx, w1_nx, w2_nx;
  logic              field_chg;
  logic              eng_done;
  logic [RATE_W-1:0] eng_result;
  logic [M_W:0]      m_start;
  logic [N_W:0]      n_start;

  pll_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .w0_q(w0_q), .w1_q(w1_q), .w2_q(w2_q),
    .w0_nx(w0_nx), .w1_nx(w1_nx), .w2_nx(w2_nx),
    .fields_chg(field_chg), .rdata(reg_rdata)
  );

  assign m_start = {1'b0, w2_nx[14:8]} + 1'b1;
  assign n_start = {1'b0, w2_nx[7:0]} + 1'b1;

  pll_rate_engine #(.REF_HZ(REF_HZ), .RATE_W(RATE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(field_chg),
    .m_dec(m_start), .n_dec(n_start), .r_sh(w1_nx[8:7]),
    .busy(rate_busy), .done(eng_done), .result(eng_result)
  );

  assign pll_enable   = w0_q[0];
  assign pll_bypass   = w0_q[15];
  assign frac_mode    = w0_q[1];
  assign frac_modulus = modulus_of(w0_q[2]);
  assign phase_rot    = w0_q[4];
  assign frac_value   = w0_q[12:6];
  assign post_div     = w1_q[8:7];
  assign fb_div_m     = {1'b0, w2_q[14:8]} + 1'b1;
  assign fb_div_n     = {1'b0, w2_q[7:0]} + 1'b1;

  assign rate_word = pll_bypass ? 32'(REF_HZ)
                   : frac_mode  ? 32'(FRAC_CODE)
                   : 32'(eng_result);
endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk #(
  parameter int LAT = 42
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        field_chg,
  input logic        rate_busy,
  input logic        eng_done,
  input logic [31:0] reg_rdata,
  input logic [6:0]  frac_modulus
);
  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= '0;
    else if (field_chg)  run_cnt <= '0;
    else if (rate_busy)  run_cnt <= run_cnt + 1'b1;
    else                 run_cnt <= '0;
  end

  AST_BUSY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    field_chg |=> rate_busy); // R8
  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !field_chg && !rate_busy) |=> !rate_busy); // R9
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !field_chg) |=> !rate_busy); // R8
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 8'(LAT)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0); // R2
  AST_MOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_modulus == 7'd91) || (frac_modulus == 7'd55)); // R12
endmodule

bind pll_cfg_if pll_cfg_chk #(.LAT(RATE_W + pll_cfg_pkg::N_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .field_chg(field_chg),
  .rate_busy(rate_busy), .eng_done(eng_done), .reg_rdata(reg_rdata),
  .frac_modulus(frac_modulus)
);

// File: tb/tb_pll_cfg_if.sv
module tb_pll_cfg_if;
  localparam int REF = 27_000_000;
  localparam int LATENCY = 42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pll_enable, pll_bypass, frac_mode, phase_rot, rate_busy;
  logic [6:0]  frac_modulus, frac_value;
  logic [1:0]  post_div;
  logic [7:0]  fb_div_m;
  logic [8:0]  fb_div_n;
  logic [31:0] rate_word;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_cfg_if dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_enable(pll_enable),
    .pll_bypass(pll_bypass), .frac_mode(frac_mode), .frac_modulus(frac_modulus),
    .phase_rot(phase_rot), .frac_value(frac_value), .post_div(post_div),
    .fb_div_m(fb_div_m), .fb_div_n(fb_div_n), .rate_busy(rate_busy),
    .rate_word(rate_word)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic longint exp_rate(input int m, input int n, input int r);
    longint p;
    p = ((longint'(REF) / m) * n) >>> r;
    if (p > 64'hFFFF_FFFE) p = 64'hFFFF_FFFE;
    return p;
  endfunction

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (rate_busy && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic set_int(input int m, input int n, input int r);
    int cyc;
    do_write(4'h8, {16'h7FFF, 1'b0, 7'(m - 1), 8'(n - 1)});
    do_write(4'h4, {16'h0180, 7'h0, 2'(r), 7'h0});
    wait_idle(cyc);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    do_read(4'h0, rd); check("R11 word0", rd, 0);
    do_read(4'h4, rd); check("R11 word1", rd, 0);
    do_read(4'h8, rd); check("R11 word2", rd, 0);
    check("R11 rate", rate_word, REF);
    check("R11 busy", rate_busy, 0);
    check("R11 enable", pll_enable, 0);

    // R1 / R4 masked writes on word 0 bit 0
    do_write(4'h0, 32'h0001_FFFF);
    do_read(4'h0, rd); check("R1 mask one bit", rd, 32'h1);
    check("R4 enabled", pll_enable, 1);
    check("R9 power bit no busy", rate_busy, 0);
    do_write(4'h0, 32'h0000_0000);
    do_read(4'h0, rd); check("R1 zero mask keeps", rd, 32'h1);
    check("R9 zero mask no busy", rate_busy, 0);
    do_write(4'h0, 32'h0001_0000);
    check("R4 disabled", pll_enable, 0);

    // R2 invalid offsets
    do_write(4'hC, 32'hFFFF_FFFF);
    do_write(4'h2, 32'hFFFF_FFFF);
    do_read(4'hC, rd); check("R2 offset C reads 0", rd, 0);
    do_read(4'h2, rd); check("R2 offset 2 reads 0", rd, 0);
    do_read(4'h0, rd); check("R2 word0 untouched", rd, 0);
    do_read(4'h4, rd); check("R2 word1 untouched", rd, 0);
    check("R2 no busy", rate_busy, 0);

    // R1 partial mask on word 1, affects R field
    do_write(4'h4, 32'hF0F0_AAAA);
    do_read(4'h4, rd); check("R1 partial mask", rd, 32'hA0A0);
    check("R8 busy after R change", rate_busy, 1);
    wait_idle(cyc);
    check("R3 post_div", post_div, 1);
    check("R5 rate R=1", rate_word, exp_rate(1, 1, 1));

    // R8 exact latency
    do_write(4'h8, 32'h7FFF_0203);
    wait_idle(cyc);
    check("R8 latency", cyc, LATENCY);
    check("R3 fb_div_m", fb_div_m, 3);
    check("R3 fb_div_n", fb_div_n, 4);
    check("R5 rate m3 n4", rate_word, exp_rate(3, 4, 1));

    // R9 same-value write
    do_write(4'h8, 32'h7FFF_0203);
    check("R9 same value no busy", rate_busy, 0);

    // R6 bypass
    do_write(4'h0, 32'h8000_8000);
    check("R9 bypass no busy", rate_busy, 0);
    check("R6 bypass rate", rate_word, REF);
    check("R3 bypass port", pll_bypass, 1);
    do_write(4'h0, 32'h8000_0000);
    check("R6 bypass off rate", rate_word, exp_rate(3, 4, 1));

    // R7 / R12 / R3 fractional fields
    do_write(4'h0, 32'h1FD6_0F52);
    check("R8 busy on frac change", rate_busy, 1);
    wait_idle(cyc);
    check("R7 frac code", rate_word, 64'hFFFF_FFFF);
    check("R3 frac_mode", frac_mode, 1);
    check("R3 phase_rot", phase_rot, 1);
    check("R3 frac_value", frac_value, 7'h3D);
    check("R12 modulus 91", frac_modulus, 91);
    do_write(4'h0, 32'h0004_0004);
    wait_idle(cyc);
    check("R12 modulus 55", frac_modulus, 55);
    do_write(4'h0, 32'h8000_8000);
    check("R6 bypass over frac", rate_word, REF);
    do_write(4'h0, 32'hFFFF_0000);
    wait_idle(cyc);

    // R5 sweep over all M
    for (int m = 1; m <= 128; m++) begin
      int n = ((m * 37) % 256) + 1;
      set_int(m, n, m % 4);
      check("R5 M sweep", rate_word, exp_rate(m, n, m % 4));
      check("R3 M decode", fb_div_m, m);
    end
    // R5 sweep over all N
    for (int n = 1; n <= 256; n++) begin
      set_int(3, n, n % 4);
      check("R5 N sweep", rate_word, exp_rate(3, n, n % 4));
      check("R3 N decode", fb_div_n, n);
    end
    set_int(1, 256, 0);
    check("R5 saturation", rate_word, 64'hFFFF_FFFE);

    // R10 restart during computation
    do_write(4'h8, {16'h7FFF, 1'b0, 7'd4, 8'd9});
    repeat (10) @(negedge clk);
    do_write(4'h8, {16'h7FFF, 1'b0, 7'd6, 8'd19});
    wait_idle(cyc);
    check("R10 restart latency", cyc, LATENCY);
    check("R10 latest rate", rate_word, exp_rate(7, 20, 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule